// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the controller for a processor datapath that runs each instruction over several short clock cycles instead of one long one. The datapath shares one memory, one ALU and one register file between all steps of an instruction. The controller is a Moore state machine. It reads the 6-bit opcode field held in the instruction register and drives every strobe and multiplexer select the datapath needs, one state per clock. Every instruction starts with a fetch step and then a decode step. It then follows a short path that depends on its class: load, store, register-to-register arithmetic (R-type), branch-if-equal or jump.

During decode the controller raises a target-capture strobe. This lets a separate register hold the precomputed branch target while the ALU is still free. A branch then needs only one compare step. All control outputs depend on the current state alone. Any strobe that a state does not assert is low. Any select that a state does not list is driven to 0, so the outputs are fully defined in every state.

States and transitions:
- FETCH → DECODE
- DECODE → ADDR_CALC on load or store, → R_EXEC on R-type, → BR_DONE on branch-equal, → J_DONE on jump, → FETCH on any other opcode
- ADDR_CALC → MEM_LD on load, → MEM_ST on store, → FETCH otherwise
- MEM_LD → LD_WB
- R_EXEC → R_WB
- MEM_ST, LD_WB, R_WB, BR_DONE and J_DONE → FETCH

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the machine in FETCH on that edge, from any state.
- R2: In FETCH the controller asserts `mem_rd`, `ir_wr` and `pc_wr`, with `addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_op`=00 and `pc_src`=00. The next state is always DECODE.
- R3: In DECODE the controller sets `alu_a_sel`=0, `alu_b_sel`=11 and `alu_op`=00, and asserts `tgt_wr`. The next state is chosen from the opcode: 100011 (load) or 101011 (store) go to ADDR_CALC, 000000 (R-type) goes to R_EXEC, 000100 (branch-equal) goes to BR_DONE, and 000010 (jump) goes to J_DONE.
- R4: In ADDR_CALC the controller sets `alu_a_sel`=1, `alu_b_sel`=10 and `alu_op`=00. The next state is MEM_LD for a load opcode and MEM_ST for a store opcode.
- R5: In MEM_LD the controller asserts `mem_rd` with `addr_sel`=1. The next state is LD_WB.
- R6: In MEM_ST the controller asserts `mem_wr` with `addr_sel`=1. The next state is FETCH.
- R7: In LD_WB the controller asserts `rf_wr` with `wb_sel`=1 and `dst_sel`=0. The next state is FETCH.
- R8: In R_EXEC the controller sets `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10. The next state is R_WB.
- R9: In R_WB the controller asserts `rf_wr` with `dst_sel`=1 and `wb_sel`=0. The next state is FETCH.
- R10: In BR_DONE the controller sets `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=01, asserts `pc_wr_cond`, and sets `pc_src`=01. The next state is FETCH.
- R11: In J_DONE the controller asserts `pc_wr` with `pc_src`=10. The next state is FETCH.
- R12: An opcode outside the five listed in R3 makes DECODE return to FETCH. No memory, register-file or PC write occurs on that path.
- R13: In every state, each strobe the state does not assert is 0 and each select the state does not list is 0. `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if the ALU zero flag is set |
| pc_src | output | 2 | PC source: 00 ALU result, 01 branch target register, 10 jump address |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| wb_sel | output | 1 | Register write data: 0 ALU, 1 memory data |
| rf_wr | output | 1 | Register file write strobe |
| dst_sel | output | 1 | Destination register field: 0 rt, 1 rd |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 sign-extended immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| tgt_wr | output | 1 | Branch-target register load |

## Verification
The bench runs a sequence of load, store, R-type, branch, jump and unknown opcodes. It compares all 17 control bits on every clock against a behavioural model of the state sequence. An unknown opcode is the main corner case. A design that sent it down some execution path would raise a memory or register write where the model expects FETCH. Swapped load and store branches in ADDR_CALC would show as `mem_wr` where `mem_rd` is expected, and a missing write-back step would shift every later cycle out of line. A reset raised during R_EXEC checks that the R-type write is abandoned; a design that ignored reset or finished the instruction would show `rf_wr` instead of the fetch outputs.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    parameter int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;

    typedef enum logic [3:0] {
        ST_FETCH     = 4'd0,
        ST_DECODE    = 4'd1,
        ST_ADDR_CALC = 4'd2,
        ST_MEM_LD    = 4'd3,
        ST_MEM_ST    = 4'd4,
        ST_LD_WB     = 4'd5,
        ST_R_EXEC    = 4'd6,
        ST_R_WB      = 4'd7,
        ST_BR_DONE   = 4'd8,
        ST_J_DONE    = 4'd9
    } state_e;

    // Operand and PC select codes
    localparam logic [1:0] PCS_ALU  = 2'b00;
    localparam logic [1:0] PCS_TGT  = 2'b01;
    localparam logic [1:0] PCS_JMP  = 2'b10;
    localparam logic [1:0] BSEL_REG = 2'b00;
    localparam logic [1:0] BSEL_FOUR = 2'b01;
    localparam logic [1:0] BSEL_IMM = 2'b10;
    localparam logic [1:0] BSEL_OFS = 2'b11;
    localparam logic [1:0] AOP_ADD  = 2'b00;
    localparam logic [1:0] AOP_SUB  = 2'b01;
    localparam logic [1:0] AOP_FUNC = 2'b10;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic [1:0] pc_src;
        logic       addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       wb_sel;
        logic       rf_wr;
        logic       dst_sel;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_op;
        logic       tgt_wr;
    } ctrl_t;

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
    import mc_ctrl_pkg::*;
(
    input  state_e           cur,
    input  logic [OPC_W-1:0] opcode,
    output state_e           nxt
);

    logic is_mem;
    logic is_load;
    logic is_store;

    always_comb begin
        is_load  = (opcode == OPC_LOAD);
        is_store = (opcode == OPC_STORE);
        is_mem   = is_load | is_store;
    end

    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH: nxt = ST_DECODE;
            ST_DECODE: begin
                if (is_mem)                    nxt = ST_ADDR_CALC;
                else if (opcode == OPC_RTYPE)  nxt = ST_R_EXEC;
                else if (opcode == OPC_BEQ)    nxt = ST_BR_DONE;
                else if (opcode == OPC_JUMP)   nxt = ST_J_DONE;
                else                           nxt = ST_FETCH;
            end
            ST_ADDR_CALC: begin
                if (is_load)       nxt = ST_MEM_LD;
                else if (is_store) nxt = ST_MEM_ST;
                else               nxt = ST_FETCH;
            end
            ST_MEM_LD:  nxt = ST_LD_WB;
            ST_R_EXEC:  nxt = ST_R_WB;
            ST_MEM_ST,
            ST_LD_WB,
            ST_R_WB,
            ST_BR_DONE,
            ST_J_DONE:  nxt = ST_FETCH;
            default:    nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
    import mc_ctrl_pkg::*;
(
    input  state_e cur,
    output ctrl_t  ctl
);

    always_comb begin
        ctl = '0;
        unique case (cur)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.pc_wr     = 1'b1;
                ctl.addr_sel  = 1'b0;
                ctl.alu_a_sel = 1'b0;
                ctl.alu_b_sel = BSEL_FOUR;
                ctl.alu_op    = AOP_ADD;
                ctl.pc_src    = PCS_ALU;
            end
            ST_DECODE: begin
                ctl.alu_a_sel = 1'b0;
                ctl.alu_b_sel = BSEL_OFS;
                ctl.alu_op    = AOP_ADD;
                ctl.tgt_wr    = 1'b1;
            end
            ST_ADDR_CALC: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_IMM;
                ctl.alu_op    = AOP_ADD;
            end
            ST_MEM_LD: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_MEM_ST: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_LD_WB: begin
                ctl.rf_wr   = 1'b1;
                ctl.wb_sel  = 1'b1;
                ctl.dst_sel = 1'b0;
            end
            ST_R_EXEC: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_REG;
                ctl.alu_op    = AOP_FUNC;
            end
            ST_R_WB: begin
                ctl.rf_wr   = 1'b1;
                ctl.dst_sel = 1'b1;
                ctl.wb_sel  = 1'b0;
            end
            ST_BR_DONE: begin
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_b_sel  = BSEL_REG;
                ctl.alu_op     = AOP_SUB;
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_src     = PCS_TGT;
            end
            ST_J_DONE: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = PCS_JMP;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic [1:0]       pc_src,
    output logic             addr_sel,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_wr,
    output logic             wb_sel,
    output logic             rf_wr,
    output logic             dst_sel,
    output logic             alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic [1:0]       alu_op,
    output logic             tgt_wr
);

    state_e state_q;
    state_e state_d;
    ctrl_t  ctl;

    mc_ctrl_next u_next (
        .cur    (state_q),
        .opcode (opcode),
        .nxt    (state_d)
    );

    mc_ctrl_decode u_dec (
        .cur (state_q),
        .ctl (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    always_comb begin
        pc_wr      = ctl.pc_wr;
        pc_wr_cond = ctl.pc_wr_cond;
        pc_src     = ctl.pc_src;
        addr_sel   = ctl.addr_sel;
        mem_rd     = ctl.mem_rd;
        mem_wr     = ctl.mem_wr;
        ir_wr      = ctl.ir_wr;
        wb_sel     = ctl.wb_sel;
        rf_wr      = ctl.rf_wr;
        dst_sel    = ctl.dst_sel;
        alu_a_sel  = ctl.alu_a_sel;
        alu_b_sel  = ctl.alu_b_sel;
        alu_op     = ctl.alu_op;
        tgt_wr     = ctl.tgt_wr;
    end

endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk
    import mc_ctrl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [OPC_W-1:0] opcode,
    input logic             pc_wr,
    input logic             pc_wr_cond,
    input logic [1:0]       pc_src,
    input logic             addr_sel,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             ir_wr,
    input logic             wb_sel,
    input logic             rf_wr,
    input logic             dst_sel,
    input logic [1:0]       alu_op
);

    assert_reset_fetch_R1: assert property (@(posedge clk)
        rst |=> (ir_wr && mem_rd && pc_wr));

    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (!ir_wr && !mem_rd && !pc_wr));

    assert_jump_dispatch_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(ir_wr) && opcode == OPC_JUMP && !ir_wr) |=> (pc_wr && pc_src == PCS_JMP));

    assert_load_chain_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && addr_sel) |=> (rf_wr && wb_sel && !dst_sel));

    assert_rtype_chain_R8: assert property (@(posedge clk) disable iff (rst)
        (alu_op == AOP_FUNC) |=> (rf_wr && dst_sel && !wb_sel));

    assert_writeback_return_R9: assert property (@(posedge clk) disable iff (rst)
        rf_wr |=> ir_wr);

    assert_branch_return_R10: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond |=> ir_wr);

    assert_store_return_R6: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_wr);

    assert_mem_exclusive_R13: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

endmodule

bind mc_ctrl_fsm mc_ctrl_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .opcode     (opcode),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .pc_src     (pc_src),
    .addr_sel   (addr_sel),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .ir_wr      (ir_wr),
    .wb_sel     (wb_sel),
    .rf_wr      (rf_wr),
    .dst_sel    (dst_sel),
    .alu_op     (alu_op)
);

// File: tb/mc_ctrl_fsm_tb.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_tb_top;

    // Model state numbering (bench-local)
    localparam int M_FETCH = 0, M_DEC = 1, M_ADDR = 2, M_MLD = 3, M_MST = 4,
                   M_LDWB = 5, M_REX = 6, M_RWB = 7, M_BR = 8, M_J = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr;
    logic       wb_sel, rf_wr, dst_sel, alu_a_sel, tgt_wr;
    logic [1:0] pc_src, alu_b_sel, alu_op;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  m_state  = M_FETCH;
    int  m_prev   = M_FETCH;
    bit  m_valid  = 1'b0;
    bit  m_rst_seen = 1'b0;
    bit  done     = 1'b0;
    int  prog[$];

    always #2.5 clk = ~clk;

    mc_ctrl_fsm dut_i (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src),
        .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
        .wb_sel(wb_sel), .rf_wr(rf_wr), .dst_sel(dst_sel),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
        .tgt_wr(tgt_wr)
    );

    // Expected 17-bit vector: pc_wr, pc_wr_cond, pc_src[2], addr_sel, mem_rd,
    // mem_wr, ir_wr, wb_sel, rf_wr, dst_sel, alu_a_sel, alu_b_sel[2], alu_op[2], tgt_wr
    function automatic logic [16:0] expect_vec(int s);
        logic pw = 0, pwc = 0, as = 0, mr = 0, mw = 0, iw = 0;
        logic ws = 0, rw = 0, ds = 0, aa = 0, tw = 0;
        logic [1:0] ps = 0, ab = 0, ao = 0;
        case (s)
            M_FETCH: begin mr = 1; iw = 1; pw = 1; ab = 2'b01; end
            M_DEC:   begin ab = 2'b11; tw = 1; end
            M_ADDR:  begin aa = 1; ab = 2'b10; end
            M_MLD:   begin mr = 1; as = 1; end
            M_MST:   begin mw = 1; as = 1; end
            M_LDWB:  begin rw = 1; ws = 1; end
            M_REX:   begin aa = 1; ao = 2'b10; end
            M_RWB:   begin rw = 1; ds = 1; end
            M_BR:    begin aa = 1; ao = 2'b01; pwc = 1; ps = 2'b01; end
            M_J:     begin pw = 1; ps = 2'b10; end
            default: ;
        endcase
        return {pw, pwc, ps, as, mr, mw, iw, ws, rw, ds, aa, ab, ao, tw};
    endfunction

    function automatic string req_tag(int s, int prev, bit after_rst);
        if (after_rst) return "R1";
        if (prev == M_DEC && s == M_FETCH) return "R12";
        case (s)
            M_FETCH: return "R2";
            M_DEC:   return "R3";
            M_ADDR:  return "R4";
            M_MLD:   return "R5";
            M_MST:   return "R6";
            M_LDWB:  return "R7";
            M_REX:   return "R8";
            M_RWB:   return "R9";
            M_BR:    return "R10";
            M_J:     return "R11";
            default: return "R13";
        endcase
    endfunction

    // Behavioural reference model of the state sequence
    always @(posedge clk) begin
        m_prev = m_state;
        if (rst) begin
            m_state = M_FETCH;
            m_valid = 1'b1;
            m_rst_seen = 1'b1;
        end else begin
            m_rst_seen = 1'b0;
            case (m_state)
                M_FETCH: m_state = M_DEC;
                M_DEC: begin
                    if (opcode == 6'b100011 || opcode == 6'b101011) m_state = M_ADDR;
                    else if (opcode == 6'b000000) m_state = M_REX;
                    else if (opcode == 6'b000100) m_state = M_BR;
                    else if (opcode == 6'b000010) m_state = M_J;
                    else m_state = M_FETCH;
                end
                M_ADDR:  m_state = (opcode == 6'b100011) ? M_MLD :
                                   (opcode == 6'b101011) ? M_MST : M_FETCH;
                M_MLD:   m_state = M_LDWB;
                M_REX:   m_state = M_RWB;
                default: m_state = M_FETCH;
            endcase
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (m_valid && !done) begin
            logic [16:0] act;
            logic [16:0] exp_v;
            act = {pc_wr, pc_wr_cond, pc_src, addr_sel, mem_rd, mem_wr, ir_wr,
                   wb_sel, rf_wr, dst_sel, alu_a_sel, alu_b_sel, alu_op, tgt_wr};
            exp_v = expect_vec(m_state);
            n_checks++;
            if (act !== exp_v) begin
                n_fail++;
                $display("FAIL %s (R13 full control vector) state=%0d actual=%b expected=%b",
                         req_tag(m_state, m_prev, m_rst_seen), m_state, act, exp_v);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // load, store, R-type, branch, jump, unknown opcodes, then more mixes
        prog = '{6'b100011, 6'b101011, 6'b000000, 6'b000100, 6'b000010,
                 6'b111111, 6'b001000, 6'b100011, 6'b000010, 6'b101011,
                 6'b000000, 6'b100010, 6'b000100};
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        while (prog.size() > 0) begin
            @(negedge clk);
            if (m_state == M_FETCH) opcode = 6'(prog.pop_front());
        end
        // drain last instruction
        repeat (6) @(negedge clk);
        // R1: reset in the middle of an R-type instruction
        while (m_state != M_FETCH) @(negedge clk);
        opcode = 6'b000000;
        while (m_state != M_REX) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        opcode = 6'b000010;
        repeat (6) @(negedge clk);
        finish_run();
    end

endmodule